// File: doc/BRIEF.md
# Byte-Stream Bus Bridge Host Packetizer

This block is the requesting end of a bridge that carries bus reads and writes over a serial byte link. A client presents a request on a request port: a byte address, a word count, a direction and a burst type. The block turns it into a command frame on an outgoing byte stream that feeds a UART transmitter. Each frame is a header: one opcode byte, one word-count byte and four bytes of word index, most significant first. For a write, the header is followed by the payload words, each sent as four bytes with the most significant first.

Write payload arrives on a word stream and is taken one word at a time. Long writes are cut into frames of at most eight words, and every frame carries its own header. An incrementing write moves each later frame's index past the words already sent. A fixed-address write repeats the same index in every frame. A read sends only a header. The block then collects exactly count words from the incoming byte stream, four bytes each with the most significant first, and delivers them on a 32-bit read stream.

Incoming bytes that arrive while no read response is expected are drained and dropped, so stale link traffic cannot mix into a new response. Requests with a word count of zero are accepted and then dropped. The controller has five states. ST_IDLE accepts requests. ST_HEADER sends the header bytes. ST_WR_FETCH takes a payload word. ST_WR_SEND sends the payload bytes. ST_RD_COLLECT gathers and hands out response words. The transitions are: accept (IDLE to HEADER), header-done (HEADER to WR_FETCH or RD_COLLECT), fetched (WR_FETCH to WR_SEND), word-sent (WR_SEND to WR_FETCH), next-chunk (WR_SEND to HEADER), write-done (WR_SEND to IDLE) and read-done (RD_COLLECT to IDLE).

Top module: `serbus_host`

## Requirements
- R1: The first header byte is the opcode: 0x01 incrementing write, 0x02 incrementing read, 0x03 fixed-address write, 0x04 fixed-address read.
- R2: The header is six bytes in this order: opcode, word count of the frame, then the word index (byte address shifted right by 2) as four bytes, most significant first.
- R3: After a write header, each payload word of that frame is sent as four bytes, most significant first, in the order the words were accepted on the write stream.
- R4: A write of N words is sent as frames of 8 words each, followed by one frame of the remaining words if N is not a multiple of 8. Each frame has its own header and word count.
- R5: For an incrementing write, the word index of each later frame equals the previous frame's index plus the previous frame's word count.
- R6: For a fixed-address write, every frame carries the word index of the request.
- R7: After a read header has been fully sent, exactly count words (1 to 255) are built from the incoming bytes, four bytes per word with the most significant first, and are presented on the read stream.
- R8: Incoming bytes that arrive while the block is idle are accepted (rx_ready high) and discarded, with no effect on later read data.
- R9: A request with a word count of 0 is accepted, sends no bytes, and leaves busy low.
- R10: busy is high from the cycle after a non-zero request is accepted until the last write byte or the last read word has been handed over. req_ready is high only while busy is low, and no byte or word is offered while busy is low.
- R11: While tx_valid or rd_valid is high and not accepted, the offered value stays stable and remains valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fixed | input | 1 | 1 = fixed address, 0 = incrementing |
| req_addr | input | 32 | Byte address |
| req_count | input | 8 | Number of words |
| wr_valid | input | 1 | Write payload word present |
| wr_ready | output | 1 | Write payload word taken |
| wr_data | input | 32 | Write payload word |
| tx_valid | output | 1 | Outgoing byte present |
| tx_ready | input | 1 | Outgoing byte taken |
| tx_data | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Incoming byte taken |
| rx_data | input | 8 | Incoming byte |
| rd_valid | output | 1 | Read word present |
| rd_ready | input | 1 | Read word taken |
| rd_data | output | 32 | Read word |
| busy | output | 1 | Request in progress |

## Verification
The bench builds the block with its default parameters: 32-bit words and addresses, an 8-bit count, and a chunk of eight words. With these values a write of 19 words splits into three frames and a write of 10 words splits into two. Exact multiples of eight and a maximal 255-word read are also reachable. Fixed and incrementing variants of each are run, under periodic back-pressure on both output streams.

// File: rtl/serbus_host_pkg.sv
package serbus_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_WR_FETCH,
        ST_WR_SEND,
        ST_RD_COLLECT
    } host_state_e;

    localparam logic [7:0] OP_WR_INCR  = 8'h01;
    localparam logic [7:0] OP_RD_INCR  = 8'h02;
    localparam logic [7:0] OP_WR_FIXED = 8'h03;
    localparam logic [7:0] OP_RD_FIXED = 8'h04;

    function automatic logic [7:0] op_code(input logic is_wr, input logic is_fx);
        if (is_wr) return is_fx ? OP_WR_FIXED : OP_WR_INCR;
        return is_fx ? OP_RD_FIXED : OP_RD_INCR;
    endfunction

endpackage

// File: rtl/serbus_frame_mux.sv
module serbus_frame_mux #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int IDX_W  = 3
) (
    input  logic              hdr_sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        opcode,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [ADDR_W-1:0] widx,
    input  logic [DATA_W-1:0] word,
    output logic [7:0]        byte_o
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int HDR_BYTES  = 2 + ADDR_BYTES;

    logic [7:0] hdr_b [HDR_BYTES];
    logic [7:0] dat_b [WORD_BYTES];

    assign hdr_b[0] = opcode;
    assign hdr_b[1] = 8'(cnt);

    generate
        for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr_byte
            assign hdr_b[2+g] = widx[ADDR_W-1-8*g -: 8];
        end
        for (genvar g = 0; g < WORD_BYTES; g++) begin : g_data_byte
            assign dat_b[g] = word[DATA_W-1-8*g -: 8];
        end
    endgenerate

    always_comb begin
        byte_o = '0;
        if (hdr_sel) begin
            for (int k = 0; k < HDR_BYTES; k++) begin
                if (idx == IDX_W'(k)) byte_o = hdr_b[k];
            end
        end else begin
            for (int k = 0; k < WORD_BYTES; k++) begin
                if (idx == IDX_W'(k)) byte_o = dat_b[k];
            end
        end
    end

endmodule

// File: rtl/serbus_word_pack.sv
module serbus_word_pack #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              collect,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [DATA_W-1:0] word_data
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int BC_W       = $clog2(WORD_BYTES);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(WORD_BYTES - 1);

    logic [DATA_W-9:0] shreg;
    logic [BC_W-1:0]   bcnt;
    logic              out_v;
    logic [DATA_W-1:0] out_d;
    logic              take;

    assign rx_ready   = collect ? !out_v : 1'b1;
    assign take       = collect && rx_valid && !out_v;
    assign word_valid = out_v;
    assign word_data  = out_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            bcnt  <= '0;
            out_v <= 1'b0;
            out_d <= '0;
        end else if (clear) begin
            bcnt  <= '0;
            out_v <= 1'b0;
        end else begin
            if (out_v && word_ready) out_v <= 1'b0;
            if (take) begin
                if (bcnt == BC_LAST) begin
                    out_d <= {shreg, rx_data};
                    out_v <= 1'b1;
                    bcnt  <= '0;
                end else begin
                    shreg <= {shreg[DATA_W-17:0], rx_data};
                    bcnt  <= bcnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/serbus_host.sv
module serbus_host
    import serbus_host_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 8,
    parameter int CHUNK_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_fixed,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int HDR_BYTES  = 2 + ADDR_BYTES;
    localparam int IDX_W      = $clog2(HDR_BYTES > WORD_BYTES ? HDR_BYTES : WORD_BYTES);
    localparam int LSB_DROP   = $clog2(WORD_BYTES);
    localparam logic [CNT_W-1:0] CHUNK_C   = CNT_W'(CHUNK_WORDS);
    localparam logic [IDX_W-1:0] HDR_LAST  = IDX_W'(HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(WORD_BYTES - 1);

    host_state_e       state, state_nx;
    logic              wr_mode, fx_mode;
    logic [ADDR_W-1:0] frame_addr;
    logic [CNT_W-1:0]  frame_cnt, frame_left, remaining;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] wr_word;

    logic              req_fire, tx_fire, wr_fire, rd_fire;
    logic              req_zero;
    logic [CNT_W-1:0]  first_cnt, next_cnt;
    logic [ADDR_W-1:0] req_widx;
    logic              hdr_sel, collect;
    logic              addr_unused;

    assign req_fire  = req_valid && req_ready;
    assign tx_fire   = tx_valid && tx_ready;
    assign wr_fire   = wr_valid && wr_ready;
    assign rd_fire   = rd_valid && rd_ready;
    assign req_zero  = (req_count == '0);
    assign first_cnt = (req_write && req_count > CHUNK_C) ? CHUNK_C : req_count;
    assign next_cnt  = (remaining > CHUNK_C) ? CHUNK_C : remaining;
    assign req_widx  = {{LSB_DROP{1'b0}}, req_addr[ADDR_W-1:LSB_DROP]};
    assign addr_unused = ^req_addr[LSB_DROP-1:0];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_fire && !req_zero) state_nx = ST_HEADER;          // accept
            end
            ST_HEADER: begin
                if (tx_fire && idx == HDR_LAST)                           // header-done
                    state_nx = wr_mode ? ST_WR_FETCH : ST_RD_COLLECT;
            end
            ST_WR_FETCH: begin
                if (wr_fire) state_nx = ST_WR_SEND;                       // fetched
            end
            ST_WR_SEND: begin
                if (tx_fire && idx == DATA_LAST) begin
                    if (frame_left != CNT_W'(1)) state_nx = ST_WR_FETCH;  // word-sent
                    else if (remaining != '0)    state_nx = ST_HEADER;    // next-chunk
                    else                         state_nx = ST_IDLE;      // write-done
                end
            end
            ST_RD_COLLECT: begin
                if (rd_fire && frame_left == CNT_W'(1)) state_nx = ST_IDLE; // read-done
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        busy      = (state != ST_IDLE);
        hdr_sel   = (state == ST_HEADER);
        tx_valid  = (state == ST_HEADER) || (state == ST_WR_SEND);
        wr_ready  = (state == ST_WR_FETCH);
        collect   = (state == ST_RD_COLLECT);
    end

    // Request context and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_mode    <= 1'b0;
            fx_mode    <= 1'b0;
            frame_addr <= '0;
            frame_cnt  <= '0;
            frame_left <= '0;
            remaining  <= '0;
            idx        <= '0;
            wr_word    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_fire && !req_zero) begin
                        wr_mode    <= req_write;
                        fx_mode    <= req_fixed;
                        frame_addr <= req_widx;
                        frame_cnt  <= first_cnt;
                        frame_left <= first_cnt;
                        remaining  <= req_count - first_cnt;
                        idx        <= '0;
                    end
                end
                ST_HEADER: begin
                    if (tx_fire) idx <= (idx == HDR_LAST) ? '0 : idx + 1'b1;
                end
                ST_WR_FETCH: begin
                    if (wr_fire) begin
                        wr_word <= wr_data;
                        idx     <= '0;
                    end
                end
                ST_WR_SEND: begin
                    if (tx_fire) begin
                        if (idx == DATA_LAST) begin
                            idx        <= '0;
                            frame_left <= frame_left - 1'b1;
                            if (frame_left == CNT_W'(1) && remaining != '0) begin
                                if (!fx_mode) frame_addr <= frame_addr + ADDR_W'(frame_cnt);
                                frame_cnt  <= next_cnt;
                                frame_left <= next_cnt;
                                remaining  <= remaining - next_cnt;
                            end
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_RD_COLLECT: begin
                    if (rd_fire) frame_left <= frame_left - 1'b1;
                end
                default: ;
            endcase
        end
    end

    serbus_frame_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W)
    ) u_mux (
        .hdr_sel (hdr_sel),
        .idx     (idx),
        .opcode  (op_code(wr_mode, fx_mode)),
        .cnt     (frame_cnt),
        .widx    (frame_addr),
        .word    (wr_word),
        .byte_o  (tx_data)
    );

    serbus_word_pack #(
        .DATA_W (DATA_W)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (req_fire),
        .collect    (collect),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready),
        .word_valid (rd_valid),
        .word_ready (rd_ready),
        .word_data  (rd_data)
    );

endmodule

// File: rtl/serbus_host_chk.sv
module serbus_host_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic        req_fixed,
    input logic [7:0]  req_count,
    input logic        wr_ready,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic [31:0] rd_data,
    input logic        busy
);
    logic [7:0] exp_op;
    assign exp_op = req_write ? (req_fixed ? 8'h03 : 8'h01) : (req_fixed ? 8'h04 : 8'h02);

    // R1
    cmd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_count != 8'd0) |=> (tx_valid && tx_data == $past(exp_op)));

    // R9
    zero_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_count == 8'd0) |=> (!busy && !tx_valid));

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_count != 8'd0) |=> busy);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tx_valid && !wr_ready && !rd_valid));

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

bind serbus_host serbus_host_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_fixed (req_fixed),
    .req_count (req_count),
    .wr_ready  (wr_ready),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .busy      (busy)
);

// File: tb/test_serbus_host.sv
module test_serbus_host;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_fixed = 1'b0;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_count = '0;
    logic        req_ready;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        tx_valid, tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0, rx_ready;
    logic [7:0]  rx_data = '0;
    logic        rd_valid, rd_ready = 1'b0;
    logic [31:0] rd_data;
    logic        busy;

    always #10 clk = ~clk;

    serbus_host i_serbus_host (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_fixed(req_fixed), .req_addr(req_addr), .req_count(req_count),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    int tx_seen = 0;
    int cyc = 0;
    logic [7:0]  exp_tx [$];
    string       tx_tag [$];
    logic [31:0] exp_rd [$];
    string       rd_tag [$];
    logic [31:0] wr_src [$];
    logic [7:0]  rx_src [$];
    logic [7:0]  e8;
    logic [31:0] e32;
    string       etag;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Driver of free-running inputs: sources and back-pressure
    always @(posedge clk) begin
        #1;
        cyc++;
        wr_valid = (wr_src.size() > 0);
        wr_data  = wr_valid ? wr_src[0] : 32'h0;
        rx_valid = (rx_src.size() > 0);
        rx_data  = rx_valid ? rx_src[0] : 8'h0;
        tx_ready = (cyc % 3) != 0;
        rd_ready = (cyc % 4) != 1;
    end

    // Monitor and scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid && wr_ready) void'(wr_src.pop_front());
            if (rx_valid && rx_ready) void'(rx_src.pop_front());
            if (tx_valid && tx_ready) begin
                tx_seen++;
                if (exp_tx.size() == 0) begin
                    check(1'b0, "R9", "unexpected tx byte", tx_data, 0);
                end else begin
                    e8 = exp_tx.pop_front();
                    etag = tx_tag.pop_front();
                    check(tx_data == e8, etag, "tx byte", tx_data, e8);
                end
            end
            if (rd_valid && rd_ready) begin
                if (exp_rd.size() == 0) begin
                    check(1'b0, "R8", "unexpected read word", rd_data, 0);
                end else begin
                    e32 = exp_rd.pop_front();
                    etag = rd_tag.pop_front();
                    check(rd_data == e32, etag, "read word", rd_data, e32);
                end
            end
        end
    end

    task automatic push_tx(input logic [7:0] b, input string tag);
        exp_tx.push_back(b);
        tx_tag.push_back(tag);
    endtask

    task automatic push_hdr(input logic [7:0] op, input int n, input logic [31:0] widx,
                            input string atag);
        push_tx(op, "R1");
        push_tx(8'(n), "R4");
        for (int j = 3; j >= 0; j--) push_tx(widx[8*j +: 8], atag);
    endtask

    task automatic issue(input bit w, input bit f, input logic [31:0] a, input int n);
        @(posedge clk); #2;
        req_valid = 1'b1; req_write = w; req_fixed = f; req_addr = a; req_count = 8'(n);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #2;
        req_valid = 1'b0;
        @(negedge clk);
        check(busy == (n != 0), "R10", "busy after accept", busy, (n != 0));
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic run_write(input bit f, input logic [31:0] a, input int n,
                             input logic [31:0] seed);
        logic [31:0] widx;
        logic [31:0] d;
        int left, c, k;
        widx = a >> 2;
        left = n;
        k = 0;
        while (left > 0) begin
            c = (left > 8) ? 8 : left;
            push_hdr(f ? 8'h03 : 8'h01, c, widx, (k == 0) ? "R2" : (f ? "R6" : "R5"));
            for (int j = 0; j < c; j++) begin
                d = seed ^ (32'h01020304 * 32'(k + 1));
                wr_src.push_back(d);
                for (int b = 3; b >= 0; b--) push_tx(d[8*b +: 8], "R3");
                k++;
            end
            left -= c;
            if (!f) widx += 32'(c);
        end
        issue(1'b1, f, a, n);
        wait_idle();
        check(exp_tx.size() == 0, "R4", "bytes still expected", exp_tx.size(), 0);
        check(wr_src.size() == 0, "R3", "payload words not taken", wr_src.size(), 0);
    endtask

    task automatic run_read(input bit f, input logic [31:0] a, input int n,
                            input logic [31:0] seed);
        logic [31:0] d;
        int start;
        // stale bytes while idle must be drained and dropped
        for (int j = 0; j < 3; j++) rx_src.push_back(8'hE0 + 8'(j));
        @(negedge clk);
        while (rx_src.size() != 0) @(negedge clk);
        check(!rd_valid && !busy, "R8", "idle after stale bytes", rd_valid, 0);
        push_hdr(f ? 8'h04 : 8'h02, n, a >> 2, "R2");
        start = tx_seen;
        issue(1'b0, f, a, n);
        while (tx_seen < start + 6) @(negedge clk);
        for (int j = 0; j < n; j++) begin
            d = seed + 32'h10203041 * 32'(j);
            exp_rd.push_back(d);
            rd_tag.push_back("R7");
            for (int b = 3; b >= 0; b--) rx_src.push_back(d[8*b +: 8]);
        end
        wait_idle();
        check(exp_rd.size() == 0, "R7", "read words missing", exp_rd.size(), 0);
        check(exp_tx.size() == 0, "R2", "header bytes missing", exp_tx.size(), 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R10", "busy after reset", busy, 0);
        check(req_ready, "R10", "req_ready after reset", req_ready, 1);
        check(!tx_valid && !rd_valid, "R10", "outputs quiet after reset", tx_valid, 0);

        run_write(1'b0, 32'h0000_0100, 3, 32'hA5A5_0000);
        run_write(1'b1, 32'h0000_0204, 3, 32'h5A5A_1111);
        run_write(1'b0, 32'h0000_2000, 19, 32'hC0DE_0000);
        run_write(1'b1, 32'h8000_0010, 10, 32'hBEEF_0000);
        run_write(1'b0, 32'h0000_0040, 8, 32'h1234_5678);
        run_write(1'b0, 32'h0000_0044, 9, 32'h8765_4321);
        run_read(1'b0, 32'h0000_0300, 5, 32'h0102_0304);
        run_read(1'b1, 32'h4000_0008, 1, 32'hFEDC_BA98);
        run_read(1'b0, 32'h0000_1000, 255, 32'h0BAD_F00D);

        // R9: zero-count requests
        issue(1'b1, 1'b0, 32'h0000_0500, 0);
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            check(!busy && !tx_valid, "R9", "zero write stays idle", busy, 0);
        end
        issue(1'b0, 1'b1, 32'h0000_0600, 0);
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            check(!busy && !tx_valid, "R9", "zero read stays idle", busy, 0);
        end
        run_write(1'b0, 32'h0000_0700, 2, 32'h7777_0000);

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule